// File: doc/BRIEF.md
# SPI Control and Interrupt Register Block

This block sits behind a four-wire serial port and gives a host controller access to a small set of 16-bit control and status words. Every frame is sixteen bits long and full duplex. The host sends a 3-bit register address first, then a read-only flag, then twelve data bits. In the same frame the block returns the current contents of the addressed register. The serial lines are oversampled in the block's own clock domain. A frame is acted on only after chip select is released.

Four addresses are in use: a watchdog word, an operating-mode word, an interrupt-enable word and an interrupt-status word. Event inputs from elsewhere on the chip set the status bits. The host clears a status bit by writing a one to it. An active-low interrupt line is driven whenever a pending status bit is also enabled. The control fields drive output ports that feed neighbouring logic.

Top module: `spi_ctrl_regs`

## Requirements
- R1: Frames follow SPI mode 0, MSB first, with csn_i active low. The reply word shifted out on miso_o has bits 15:13 at zero. Its bits 12:0 hold the addressed register as it stood at the third SCK rising edge of the frame.
- R2: The frame carries the register address in bits 15:13. 000 selects the watchdog word, 001 the mode word, 010 interrupt enable and 011 interrupt status. Addresses 100 to 111 read as zero, and writes to them change nothing.
- R3: When frame bit 12 is one, the frame is read-only: the data is discarded and no register changes.
- R4: A frame that does not contain exactly 16 SCK rising edges before csn_i is released changes no register.
- R5: In the watchdog word, bit 11 is a writable watchdog-mode bit (reset 0) and bits 10:8 are the period code (reset 100). Bits 7:3 mirror wd_stat_i and are read-only. Bits 12 and 2:0 read as zero.
- R6: In the mode word, bits 11:10 are the mode code (reset 00) and bits 9:4 are a general control field (reset 0). Bits 12 and 3:0 read as zero.
- R7: The interrupt-enable word holds one writable bit per event in bits NUM_IRQ-1:0, reset 0. All its other bits read as zero.
- R8: An interrupt-status bit is set by a high level on its irq_event_i bit. Writing 1 to the bit at address 011 clears it. Writing 0 leaves it unchanged. All other status-word bits read as zero.
- R9: When an event arrives in the same clock cycle as a write-one-to-clear of its bit, the bit stays set.
- R10: irq_no is low exactly when some status bit and its enable bit are both one.
- R11: Asynchronous reset rst_ni restores every register to its default. The period code returns to 100 and irq_no is high.
- R12: A committed write takes effect on the (SYNC_STAGES+1)th rising clk edge after csn_i goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, which also oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial reply data to the host |
| wd_stat_i | input | 5 | Read-only watchdog status flags |
| irq_event_i | input | NUM_IRQ | Event inputs that set status bits |
| period_o | output | 3 | Watchdog period code |
| wd_mode_o | output | 1 | Watchdog mode bit |
| mode_o | output | 2 | Operating mode code |
| ctrl_o | output | 6 | General control field |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with NUM_IRQ = 8 and SYNC_STAGES = 2. Eight events allow enabled and masked status bits to be mixed in one word, and leave reserved bits above them to check for zero. Two synchronizer stages fix the commit edge at the third clock after chip select rises. This lets the bench place an event pulse exactly on a clear and so test the set-over-clear priority.

// File: rtl/spi_ctrl_regs_pkg.sv
package spi_ctrl_regs_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 12;
  localparam int RD_W    = 13;
  localparam int CNT_W   = 5;
  localparam int STAT_W  = 5;
  localparam int CTRL_W  = 6;

  localparam logic [ADDR_W-1:0] ADDR_WDOG  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_IEN   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_ISTAT = 3'd3;

  localparam logic [2:0] PERIOD_RST = 3'b100;
endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {(STAGES+1){RST_VAL}};
    else         chain_q <= {chain_q[STAGES-1:0], d_i};
  end

  assign q_o    = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_ctrl_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              cs_act_i,
  input  logic              cs_end_i,
  input  logic              mosi_i,
  input  logic [RD_W-1:0]   rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              miso_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sh_in_q;
  logic [RD_W-1:0]    sh_out_q;
  logic               load_now, shift_now;

  // address is complete at the third rising edge: two bits held plus the live one
  assign rd_addr_o = {sh_in_q[1:0], mosi_i};
  assign load_now  = cs_act_i && sck_rise_i && (cnt_q == CNT_W'(2));
  assign shift_now = cs_act_i && sck_fall_i && (cnt_q >= CNT_W'(4)) && (cnt_q <= CNT_W'(16));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sh_in_q <= '0;
    end else if (!cs_act_i) begin
      cnt_q   <= '0;
    end else if (sck_rise_i) begin
      sh_in_q <= {sh_in_q[FRAME_W-2:0], mosi_i};
      if (cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sh_out_q <= '0;
    else if (load_now)  sh_out_q <= rd_data_i;
    else if (shift_now) sh_out_q <= {sh_out_q[RD_W-2:0], 1'b0};
  end

  assign miso_o     = cs_act_i && (cnt_q >= CNT_W'(3)) && sh_out_q[RD_W-1];
  assign wr_valid_o = cs_end_i && (cnt_q == CNT_W'(16)) && !sh_in_q[DATA_W];
  assign wr_addr_o  = sh_in_q[FRAME_W-1 -: ADDR_W];
  assign wr_data_o  = sh_in_q[DATA_W-1:0];
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_ctrl_regs_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_valid_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  input  logic [STAT_W-1:0]  wd_stat_i,
  input  logic [NUM_IRQ-1:0] istat_i,
  output logic [RD_W-1:0]    rd_data_o,
  output logic               wd_mode_o,
  output logic [2:0]         period_o,
  output logic [1:0]         mode_o,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic [NUM_IRQ-1:0] ien_o
);
  logic wr_wdog, wr_mode, wr_ien;

  assign wr_wdog = wr_valid_i && (wr_addr_i == ADDR_WDOG);
  assign wr_mode = wr_valid_i && (wr_addr_i == ADDR_MODE);
  assign wr_ien  = wr_valid_i && (wr_addr_i == ADDR_IEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_mode_o <= 1'b0;
      period_o  <= PERIOD_RST;
    end else if (wr_wdog) begin
      wd_mode_o <= wr_data_i[11];
      period_o  <= wr_data_i[10:8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      ctrl_o <= '0;
    end else if (wr_mode) begin
      mode_o <= wr_data_i[11:10];
      ctrl_o <= wr_data_i[9:4];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ien_o <= '0;
    else if (wr_ien) ien_o <= wr_data_i[NUM_IRQ-1:0];
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADDR_WDOG:  rd_data_o = {1'b0, wd_mode_o, period_o, wd_stat_i, 3'b000};
      ADDR_MODE:  rd_data_o = {1'b0, mode_o, ctrl_o, 4'b0000};
      ADDR_IEN:   rd_data_o[NUM_IRQ-1:0] = ien_o;
      ADDR_ISTAT: rd_data_o[NUM_IRQ-1:0] = istat_i;
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] event_i,
  input  logic [NUM_IRQ-1:0] clr_i,
  input  logic [NUM_IRQ-1:0] ien_i,
  output logic [NUM_IRQ-1:0] istat_o,
  output logic               irq_no
);
  // set wins over clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) istat_o <= '0;
    else         istat_o <= (istat_o & ~clr_i) | event_i;
  end

  assign irq_no = ~|(istat_o & ien_i);
endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
  import spi_ctrl_regs_pkg::*;
#(
  parameter int NUM_IRQ     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               csn_i,
  input  logic               mosi_i,
  output logic               miso_o,
  input  logic [4:0]         wd_stat_i,
  input  logic [NUM_IRQ-1:0] irq_event_i,
  output logic [2:0]         period_o,
  output logic               wd_mode_o,
  output logic [1:0]         mode_o,
  output logic [5:0]         ctrl_o,
  output logic               irq_no
);
  logic sck_s, sck_rise, sck_fall;
  logic csn_s, cs_end, cs_start;
  logic mosi_s, mosi_r_unused, mosi_f_unused;
  logic               wr_valid;
  logic [ADDR_W-1:0]  wr_addr, rd_addr;
  logic [DATA_W-1:0]  wr_data;
  logic [RD_W-1:0]    rd_data;
  logic [NUM_IRQ-1:0] istat, ien, clr_mask;

  spi_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sck (
    .clk_i, .rst_ni, .d_i(sck_i), .q_o(sck_s), .rise_o(sck_rise), .fall_o(sck_fall));
  spi_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_csn (
    .clk_i, .rst_ni, .d_i(csn_i), .q_o(csn_s), .rise_o(cs_end), .fall_o(cs_start));
  spi_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_mosi (
    .clk_i, .rst_ni, .d_i(mosi_i), .q_o(mosi_s), .rise_o(mosi_r_unused), .fall_o(mosi_f_unused));

  spi_frame_engine i_frame (
    .clk_i, .rst_ni,
    .sck_rise_i (sck_rise),
    .sck_fall_i (sck_fall),
    .cs_act_i   (!csn_s),
    .cs_end_i   (cs_end),
    .mosi_i     (mosi_s),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .miso_o     (miso_o),
    .wr_valid_o (wr_valid),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data)
  );

  spi_reg_bank #(.NUM_IRQ(NUM_IRQ)) i_bank (
    .clk_i, .rst_ni,
    .wr_valid_i (wr_valid),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .wd_stat_i  (wd_stat_i),
    .istat_i    (istat),
    .rd_data_o  (rd_data),
    .wd_mode_o  (wd_mode_o),
    .period_o   (period_o),
    .mode_o     (mode_o),
    .ctrl_o     (ctrl_o),
    .ien_o      (ien)
  );

  assign clr_mask = (wr_valid && wr_addr == ADDR_ISTAT) ? wr_data[NUM_IRQ-1:0] : '0;

  spi_irq_unit #(.NUM_IRQ(NUM_IRQ)) i_irq (
    .clk_i, .rst_ni,
    .event_i (irq_event_i),
    .clr_i   (clr_mask),
    .ien_i   (ien),
    .istat_o (istat),
    .irq_no  (irq_no)
  );

  logic unused_sync;
  assign unused_sync = ^{sck_s, cs_start, mosi_r_unused, mosi_f_unused};
endmodule

// File: rtl/spi_ctrl_regs_chk.sv
module spi_ctrl_regs_chk #(
  parameter int NUM_IRQ = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               csn_i,
  input logic [NUM_IRQ-1:0] irq_event_i,
  input logic               irq_no,
  input logic [1:0]         mode_o,
  input logic [2:0]         period_o,
  input logic [NUM_IRQ-1:0] istat,
  input logic [NUM_IRQ-1:0] ien,
  input logic               wr_valid,
  input logic [2:0]         wr_addr
);
  AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no == ((istat & ien) == '0)); // R10

  AST_EVENT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_event_i) |=> ((istat & $past(irq_event_i)) == $past(irq_event_i))); // R9

  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(istat) & ~istat)) |-> $past(wr_valid && wr_addr == 3'd3)); // R8

  AST_NO_CHANGE_MID_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csn_i && $past(!csn_i) && $past(!csn_i, 2) && $past(!csn_i, 3))
      |-> ($stable(mode_o) && $stable(period_o))); // R4
endmodule

bind spi_ctrl_regs spi_ctrl_regs_chk #(.NUM_IRQ(NUM_IRQ)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .csn_i       (csn_i),
  .irq_event_i (irq_event_i),
  .irq_no      (irq_no),
  .mode_o      (mode_o),
  .period_o    (period_o),
  .istat       (istat),
  .ien         (ien),
  .wr_valid    (wr_valid),
  .wr_addr     (wr_addr)
);

// File: tb/test_spi_ctrl_regs.sv
module test_spi_ctrl_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic       miso;
  logic [4:0] wd_stat = 5'b10110;
  logic [7:0] irq_event = '0;
  logic [2:0] period;
  logic       wd_mode;
  logic [1:0] mode;
  logic [5:0] ctrl;
  logic       irq_n;
  int checks = 0, errors = 0;
  logic [1:0] mode_n2, mode_n3;

  always #5 clk = ~clk;

  spi_ctrl_regs #(.NUM_IRQ(8), .SYNC_STAGES(2)) i_spi_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .wd_stat_i(wd_stat), .irq_event_i(irq_event),
    .period_o(period), .wd_mode_o(wd_mode), .mode_o(mode), .ctrl_o(ctrl), .irq_no(irq_n));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // evt is driven so that it is sampled on the commit edge
  task automatic spi_frame(input logic [15:0] tx, input int nbits, input logic [7:0] evt,
                           output logic [15:0] rx);
    rx = '0;
    csn = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? tx[15-i] : 1'b0;
      repeat (4) @(negedge clk);
      if (i < 16) rx[15-i] = miso;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
      repeat (4) @(negedge clk);
    end
    csn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    mode_n2 = mode;
    irq_event = evt;
    @(negedge clk);
    mode_n3 = mode;
    irq_event = '0;
    repeat (6) @(negedge clk);
  endtask

  localparam int NV = 12;
  localparam logic [31:0] VEC [NV] = '{
    {16'h1000, 16'h04B0},  // R5 R3 read watchdog word
    {16'h0AFF, 16'h04B0},  // R5 write mode bit and period
    {16'h1000, 16'h0AB0},  // R5 reserved and status bits held
    {16'h2FFF, 16'h0000},  // R6 write mode word
    {16'h3000, 16'h0FF0},  // R6 readback
    {16'h3123, 16'h0FF0},  // R3 read-only frame with data
    {16'h2410, 16'h0FF0},  // R1 old value returned during write
    {16'h3000, 16'h0410},  // R3 R6 unchanged by read-only
    {16'h4FA5, 16'h0000},  // R7 write enables
    {16'h5000, 16'h00A5},  // R7 upper bits dropped
    {16'hAFFF, 16'h0000},  // R2 unused address write
    {16'hF000, 16'h0000}   // R2 unused address reads zero
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 period", 32'(period), 32'h4);
    chk("R11 mode", 32'(mode), 32'h0);
    chk("R11 ctrl", 32'(ctrl), 32'h0);
    chk("R11 irq_no", 32'(irq_n), 32'h1);
    chk("R1 miso idle", 32'(miso), 32'h0);

    for (int v = 0; v < NV; v++) begin
      spi_frame(VEC[v][31:16], 16, 8'h00, rx);
      chk($sformatf("R1 vector %0d", v), 32'(rx), 32'(VEC[v][15:0]));
    end
    chk("R5 period_o", 32'(period), 32'h2);
    chk("R5 wd_mode_o", 32'(wd_mode), 32'h1);
    chk("R6 mode_o", 32'(mode), 32'h1);
    chk("R6 ctrl_o", 32'(ctrl), 32'h01);
    spi_frame(16'h1000, 16, 8'h00, rx);
    chk("R2 unused write left watchdog word", 32'(rx), 32'h0AB0);

    spi_frame(16'h2000, 10, 8'h00, rx);
    chk("R4 short frame", 32'(mode), 32'h1);
    spi_frame(16'h2000, 17, 8'h00, rx);
    chk("R4 long frame", 32'(mode), 32'h1);

    spi_frame(16'h2800, 16, 8'h00, rx);
    chk("R12 before commit edge", 32'(mode_n2), 32'h1);
    chk("R12 after commit edge", 32'(mode_n3), 32'h2);

    @(negedge clk); irq_event = 8'h0A;
    @(negedge clk); irq_event = 8'h00;
    repeat (2) @(negedge clk);
    chk("R10 masked events", 32'(irq_n), 32'h1);
    spi_frame(16'h7000, 16, 8'h00, rx);
    chk("R8 status set", 32'(rx), 32'h000A);
    spi_frame(16'h40FF, 16, 8'h00, rx);
    chk("R10 enabled pending", 32'(irq_n), 32'h0);
    spi_frame(16'h6002, 16, 8'h00, rx);
    chk("R1 status returned in clear frame", 32'(rx), 32'h000A);
    spi_frame(16'h7000, 16, 8'h00, rx);
    chk("R8 one clears, zero keeps", 32'(rx), 32'h0008);
    chk("R10 still pending", 32'(irq_n), 32'h0);
    spi_frame(16'h6008, 16, 8'h00, rx);
    chk("R10 released", 32'(irq_n), 32'h1);

    @(negedge clk); irq_event = 8'h01;
    @(negedge clk); irq_event = 8'h00;
    spi_frame(16'h6001, 16, 8'h01, rx);
    spi_frame(16'h7000, 16, 8'h00, rx);
    chk("R9 set beats clear", 32'(rx), 32'h0001);

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 period after reset", 32'(period), 32'h4);
    chk("R11 mode after reset", 32'(mode), 32'h0);
    chk("R11 irq_no after reset", 32'(irq_n), 32'h1);
    spi_frame(16'h5000, 16, 8'h00, rx);
    chk("R11 enables cleared", 32'(rx), 32'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule